// File: doc/BRIEF.md
# Power-Fail Supervisor with Time-Save Control

This block watches the supply state of a battery-backed real-time clock and turns it into status flags, a bus lockout and an interrupt. It reports whether timekeeping has ever been lost, flags a weak battery while the main supply is present, and locks out host bus access while the power-fail input is high. After power returns, it keeps the lockout for a programmable number of 1 ms ticks, so that the host sees a settled supply. It also decides whether a set of save registers keeps copying the live seconds, minutes, hours, day-of-month and month counters.

The host writes three small registers through a strobe, a 2-bit select and a 7-bit data word. The analog comparators and the supply switch are outside the block and arrive as synchronous digital levels. The oscillator-fail flag stays set until software starts the clock, so after reset software can tell a cold start from a recovery. The time-save enable clears itself when the supply moves to battery, so the save registers hold the last time seen on main power.

Top module: `pwr_supervisor`

## Requirements
- R1: On a synchronous reset: oscillator-fail flag 1, clock run bit 0, battery-mode bit 0, low-battery flag 0, interrupt 0, bus lockout 0, time-save enable 0, save registers 0, interrupt enable 0, debounce limit 30.
- R2: The oscillator-fail flag clears in the cycle after a control write (select 0) with data bit 0 set. That write also sets the run bit to bit 0. Nothing else clears the flag, and nothing but reset sets it.
- R3: A status write (select 1) loads the battery-mode bit from data bit 6 and leaves the oscillator-fail flag unchanged.
- R4: The low-battery flag is a registered copy of (interrupt enable AND NOT on_battery AND batt_low). Interrupt enable is control bit 1.
- R5: The interrupt sets on a rising edge of the power-fail input only while interrupt enable is 1. It stays high until a status write with data bit 0 set. A new rising edge in the same cycle takes priority over the clear.
- R6: Bus lockout asserts in the cycle after the power-fail input is high, whatever the interrupt enable is.
- R7: After the power-fail input falls, the lockout releases in the cycle after the limit-th tick. Ticks are counted from the cycle after the fall. A reassertion of the power-fail input restarts the count.
- R8: A debounce write (select 2) loads the limit from data bits 5:0. Values below 30 are raised to 30.
- R9: When time-save enable is 1 and time_upd pulses, the save registers load live_time in the next cycle. Otherwise they hold.
- R10: Time-save enable loads from control bit 2. It clears on a rising edge of on_battery, and this clear has priority over a write in the same cycle. The power-fail input does not clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_1ms | input | 1 | One-cycle pulse every millisecond |
| pwr_fail | input | 1 | Power-fail input, high while power is failing |
| on_battery | input | 1 | High while running from the backup battery |
| batt_low | input | 1 | Battery-below-threshold comparator result |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | 0 control, 1 status, 2 debounce limit |
| wr_data | input | 7 | Write data |
| time_upd | input | 1 | Live time counters updated this cycle |
| live_time | input | 40 | Live month, day, hour, minute, second (8 bits each) |
| osc_fail | output | 1 | Timekeeping-lost flag |
| clk_run | output | 1 | Clock start bit |
| batt_mode | output | 1 | Battery-backed mode bit |
| low_batt | output | 1 | Low-battery flag |
| pf_irq | output | 1 | Level power-fail interrupt |
| bus_lock | output | 1 | Host bus lockout |
| ts_en | output | 1 | Time-save enable |
| save_time | output | 40 | Saved time fields |

## Verification
The assertions check on every cycle that:
- the lockout follows a high power-fail input,
- a release happens only on a tick with the input low,
- the interrupt only rises with the enable set,
- the oscillator-fail flag only falls on a start write,
- the low-battery flag never appears on battery,
- the save registers only move on an enabled update,
- time-save tracking drops after a switch to battery.

Only the bench scenarios can show the following:
- the exact tick count before release for each limit, including the clamp and the restart after a reassertion,
- write-one-to-clear racing a new edge,
- software clearing time-save,
- a status write leaving the oscillator-fail flag alone.

// File: rtl/pwr_sup_pkg.sv
// Shared encodings for the power-fail supervisor.
// Assumes the host writes one register per strobe.
package pwr_sup_pkg;
    localparam int DATA_W   = 7;
    localparam int RUN_BIT  = 0;
    localparam int IRQE_BIT = 1;
    localparam int TSE_BIT  = 2;
    localparam int CLR_BIT  = 0;
    localparam int MODE_BIT = 6;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_STAT = 2'd1,
        SEL_DEBN = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'd0,
        LK_HELD   = 2'd1,
        LK_SETTLE = 2'd2
    } lock_st_e;
endpackage

// File: rtl/pwr_status.sv
// Status flags: oscillator-fail, run bit, battery mode, low battery, interrupt.
// Assumes all inputs are synchronous to clk.
module pwr_status
    import pwr_sup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              pwr_fail,
    input  logic              on_battery,
    input  logic              batt_low,
    output logic              osc_fail,
    output logic              clk_run,
    output logic              irq_en,
    output logic              batt_mode,
    output logic              low_batt,
    output logic              pf_irq
);
    logic pf_q;
    logic pf_rise;

    assign pf_rise = pwr_fail & ~pf_q;

    // Control bits and the sticky oscillator-fail flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            osc_fail <= 1'b1;
            clk_run  <= 1'b0;
            irq_en   <= 1'b0;
        end else if (ctrl_wr) begin
            clk_run <= wr_data[RUN_BIT];
            irq_en  <= wr_data[IRQE_BIT];
            if (wr_data[RUN_BIT]) begin
                osc_fail <= 1'b0;
            end
        end
    end

    // Battery-mode bit, loaded by status writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            batt_mode <= 1'b0;
        end else if (stat_wr) begin
            batt_mode <= wr_data[MODE_BIT];
        end
    end

    // Low-battery flag, gated by the enable and the main supply.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_batt <= 1'b0;
        end else begin
            low_batt <= irq_en & ~on_battery & batt_low;
        end
    end

    // Edge memory and the level interrupt with write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pf_q   <= 1'b0;
            pf_irq <= 1'b0;
        end else begin
            pf_q <= pwr_fail;
            if (pf_rise && irq_en) begin
                pf_irq <= 1'b1;
            end else if (stat_wr && wr_data[CLR_BIT]) begin
                pf_irq <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/pwr_lockout.sv
// Bus lockout with a tick-counted release after power returns.
// Assumes tick is a single-cycle pulse; a reasserted fail restarts the count.
module pwr_lockout
    import pwr_sup_pkg::*;
#(
    parameter int LIM_MIN = 30,
    parameter int LIM_MAX = 63,
    localparam int CNT_W  = $clog2(LIM_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             pwr_fail,
    input  logic             lim_wr,
    input  logic [CNT_W-1:0] lim_data,
    output logic             bus_lock
);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(LIM_MIN);

    lock_st_e         st;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;
    logic [CNT_W:0]   cnt_nx;

    assign cnt_nx   = {1'b0, cnt} + 1'b1;
    assign bus_lock = (st != LK_OPEN);

    // Programmable limit with a lower clamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            limit <= MIN_V;
        end else if (lim_wr) begin
            limit <= (lim_data < MIN_V) ? MIN_V : lim_data;
        end
    end

    // Lockout state and the debounce counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= LK_OPEN;
            cnt <= '0;
        end else if (pwr_fail) begin
            st  <= LK_HELD;
            cnt <= '0;
        end else begin
            case (st)
                LK_HELD: begin
                    st  <= LK_SETTLE;
                    cnt <= '0;
                end
                LK_SETTLE: begin
                    if (tick) begin
                        if (cnt_nx >= {1'b0, limit}) begin
                            st  <= LK_OPEN;
                            cnt <= '0;
                        end else begin
                            cnt <= cnt_nx[CNT_W-1:0];
                        end
                    end
                end
                default: begin
                    st  <= LK_OPEN;
                    cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/pwr_timesave.sv
// Time-save enable and save registers tracking the live time fields.
// Assumes live_time is stable in cycles where time_upd is high.
module pwr_timesave #(
    parameter int FIELD_W  = 8,
    parameter int N_FIELDS = 5,
    localparam int TIME_W  = FIELD_W * N_FIELDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ts_data,
    input  logic              on_battery,
    input  logic              time_upd,
    input  logic [TIME_W-1:0] live_time,
    output logic              ts_en,
    output logic [TIME_W-1:0] save_time
);
    logic batt_q;
    logic batt_rise;

    assign batt_rise = on_battery & ~batt_q;

    // Enable: switch to battery clears it ahead of any write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            batt_q <= 1'b0;
            ts_en  <= 1'b0;
        end else begin
            batt_q <= on_battery;
            if (batt_rise) begin
                ts_en <= 1'b0;
            end else if (ctrl_wr) begin
                ts_en <= ts_data;
            end
        end
    end

    for (genvar f = 0; f < N_FIELDS; f++) begin : g_field
        // One save field copying its live counter on enabled updates.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                save_time[f*FIELD_W +: FIELD_W] <= '0;
            end else if (ts_en && time_upd) begin
                save_time[f*FIELD_W +: FIELD_W] <= live_time[f*FIELD_W +: FIELD_W];
            end
        end
    end
endmodule

// File: rtl/pwr_supervisor.sv
// Top: register write decode plus status, lockout and time-save units.
// Assumes comparators and supply switch deliver synchronous levels.
module pwr_supervisor
    import pwr_sup_pkg::*;
#(
    parameter int FIELD_W  = 8,
    parameter int N_FIELDS = 5,
    parameter int LIM_MIN  = 30,
    parameter int LIM_MAX  = 63,
    localparam int TIME_W  = FIELD_W * N_FIELDS,
    localparam int CNT_W   = $clog2(LIM_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1ms,
    input  logic              pwr_fail,
    input  logic              on_battery,
    input  logic              batt_low,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              time_upd,
    input  logic [TIME_W-1:0] live_time,
    output logic              osc_fail,
    output logic              clk_run,
    output logic              batt_mode,
    output logic              low_batt,
    output logic              pf_irq,
    output logic              bus_lock,
    output logic              ts_en,
    output logic [TIME_W-1:0] save_time
);
    wsel_e sel;
    logic  ctrl_wr, stat_wr, debn_wr;
    logic  irq_en;

    // Write decode into per-register strobes.
    always_comb begin
        sel     = wsel_e'(wr_sel);
        ctrl_wr = wr_en && (sel == SEL_CTRL);
        stat_wr = wr_en && (sel == SEL_STAT);
        debn_wr = wr_en && (sel == SEL_DEBN);
    end

    pwr_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .stat_wr    (stat_wr),
        .wr_data    (wr_data),
        .pwr_fail   (pwr_fail),
        .on_battery (on_battery),
        .batt_low   (batt_low),
        .osc_fail   (osc_fail),
        .clk_run    (clk_run),
        .irq_en     (irq_en),
        .batt_mode  (batt_mode),
        .low_batt   (low_batt),
        .pf_irq     (pf_irq)
    );

    pwr_lockout #(
        .LIM_MIN (LIM_MIN),
        .LIM_MAX (LIM_MAX)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_1ms),
        .pwr_fail (pwr_fail),
        .lim_wr   (debn_wr),
        .lim_data (wr_data[CNT_W-1:0]),
        .bus_lock (bus_lock)
    );

    pwr_timesave #(
        .FIELD_W  (FIELD_W),
        .N_FIELDS (N_FIELDS)
    ) u_ts (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ts_data    (wr_data[TSE_BIT]),
        .on_battery (on_battery),
        .time_upd   (time_upd),
        .live_time  (live_time),
        .ts_en      (ts_en),
        .save_time  (save_time)
    );
endmodule

// File: rtl/pwr_supervisor_chk.sv
// Property checker for pwr_supervisor, attached by bind below.
module pwr_supervisor_chk #(
    parameter int TIME_W = 40
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_1ms,
    input logic              pwr_fail,
    input logic              on_battery,
    input logic              batt_low,
    input logic              wr_en,
    input logic [1:0]        wr_sel,
    input logic              wr_run,
    input logic              time_upd,
    input logic              irq_en,
    input logic              osc_fail,
    input logic              low_batt,
    input logic              pf_irq,
    input logic              bus_lock,
    input logic              ts_en,
    input logic [TIME_W-1:0] save_time
);
    p_oscfail_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_fail) |-> $past(wr_en && wr_sel == 2'd0 && wr_run));

    p_lowbatt_mains_r4: assert property (@(posedge clk) disable iff (!rst_n)
        low_batt |-> $past(!on_battery && batt_low && irq_en));

    p_irq_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_irq) |-> $past(irq_en && pwr_fail));

    p_lock_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail |=> bus_lock);

    p_release_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_lock) |-> $past(tick_1ms && !pwr_fail));

    p_save_move_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(save_time) |-> $past(ts_en && time_upd));

    p_ts_battery_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(on_battery) |=> !ts_en);
endmodule

bind pwr_supervisor pwr_supervisor_chk #(.TIME_W(TIME_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_1ms   (tick_1ms),
    .pwr_fail   (pwr_fail),
    .on_battery (on_battery),
    .batt_low   (batt_low),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_run     (wr_data[0]),
    .time_upd   (time_upd),
    .irq_en     (irq_en),
    .osc_fail   (osc_fail),
    .low_batt   (low_batt),
    .pf_irq     (pf_irq),
    .bus_lock   (bus_lock),
    .ts_en      (ts_en),
    .save_time  (save_time)
);

// File: tb/pwr_supervisor_test.sv
module pwr_supervisor_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1ms = 1'b0;
    logic        pwr_fail = 1'b0;
    logic        on_battery = 1'b0;
    logic        batt_low = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd3;
    logic [6:0]  wr_data = '0;
    logic        time_upd = 1'b0;
    logic [39:0] live_time = '0;
    logic        osc_fail, clk_run, batt_mode, low_batt, pf_irq, bus_lock, ts_en;
    logic [39:0] save_time;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc_n = 0;
    bit done  = 0;

    // reference state
    bit m_osc, m_run, m_irqe, m_mode, m_low, m_irq, m_lock, m_settle, m_ts, m_pfq, m_bq;
    int m_cnt, m_lim;
    logic [39:0] m_save;

    always #4 clk = ~clk;

    pwr_supervisor uut (
        .clk(clk), .rst_n(rst_n), .tick_1ms(tick_1ms), .pwr_fail(pwr_fail),
        .on_battery(on_battery), .batt_low(batt_low), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_data(wr_data), .time_upd(time_upd),
        .live_time(live_time), .osc_fail(osc_fail), .clk_run(clk_run),
        .batt_mode(batt_mode), .low_batt(low_batt), .pf_irq(pf_irq),
        .bus_lock(bus_lock), .ts_en(ts_en), .save_time(save_time)
    );

    // behavioural model, next state from the current state and inputs
    always @(posedge clk) begin
        bit cw, sw, dw, n_irq, n_ts;
        if (!rst_n) begin
            m_osc = 1; m_run = 0; m_irqe = 0; m_mode = 0; m_low = 0; m_irq = 0;
            m_lock = 0; m_settle = 0; m_ts = 0; m_pfq = 0; m_bq = 0;
            m_cnt = 0; m_lim = 30; m_save = '0;
        end else begin
            cw = wr_en && wr_sel == 0;
            sw = wr_en && wr_sel == 1;
            dw = wr_en && wr_sel == 2;
            m_low = m_irqe && !on_battery && batt_low;
            n_irq = m_irq;
            if (pwr_fail && !m_pfq && m_irqe) n_irq = 1;
            else if (sw && wr_data[0]) n_irq = 0;
            m_irq = n_irq;
            if (m_ts && time_upd) m_save = live_time;
            n_ts = m_ts;
            if (on_battery && !m_bq) n_ts = 0;
            else if (cw) n_ts = wr_data[2];
            m_ts = n_ts;
            if (pwr_fail) begin
                m_lock = 1; m_settle = 0; m_cnt = 0;
            end else if (m_lock && !m_settle) begin
                m_settle = 1; m_cnt = 0;
            end else if (m_settle && tick_1ms) begin
                if (m_cnt + 1 >= m_lim) begin
                    m_lock = 0; m_settle = 0; m_cnt = 0;
                end else m_cnt++;
            end
            if (dw) m_lim = (int'(wr_data[5:0]) < 30) ? 30 : int'(wr_data[5:0]);
            if (cw) begin
                m_run = wr_data[0];
                m_irqe = wr_data[1];
                if (wr_data[0]) m_osc = 0;
            end
            if (sw) m_mode = wr_data[6];
            m_pfq = pwr_fail;
            m_bq = on_battery;
        end
    end

    task automatic chk(input logic [39:0] got, input logic [39:0] exp, input string what);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %h expected %h", what, cyc_n, got, exp);
        end
    endtask

    task automatic compare();
        chk({39'd0, osc_fail},  {39'd0, m_osc},  "R2/R3 osc_fail");
        chk({39'd0, clk_run},   {39'd0, m_run},  "R2 clk_run");
        chk({39'd0, batt_mode}, {39'd0, m_mode}, "R3 batt_mode");
        chk({39'd0, low_batt},  {39'd0, m_low},  "R4 low_batt");
        chk({39'd0, pf_irq},    {39'd0, m_irq},  "R5 pf_irq");
        chk({39'd0, bus_lock},  {39'd0, m_lock}, "R6/R7/R8 bus_lock");
        chk({39'd0, ts_en},     {39'd0, m_ts},   "R10 ts_en");
        chk(save_time, m_save, "R9 save_time");
    endtask

    task automatic cyc(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            compare();
            cyc_n++;
            tick_1ms = (cyc_n % 4 == 0);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [6:0] d);
        wr_en = 1; wr_sel = s; wr_data = d;
        cyc();
        wr_en = 0; wr_sel = 2'd3; wr_data = '0;
    endtask

    task automatic upd(input logic [39:0] v);
        live_time = v; time_upd = 1;
        cyc();
        time_upd = 0;
    endtask

    initial begin
        cyc(3);
        // R1: reset values, compared against the model, plus a direct check
        chk({38'd0, osc_fail, bus_lock}, 40'd2, "R1 reset osc_fail/bus_lock");
        rst_n = 1;
        cyc(2);
        // R2: enable irq without starting the clock, the flag must stay
        wr(2'd0, 7'b0000010);
        cyc(2);
        // R3: mode bit writes must not touch the flag
        wr(2'd1, 7'h40); cyc(); wr(2'd1, 7'h00); cyc();
        chk({39'd0, osc_fail}, 40'd1, "R3 osc_fail kept");
        // R4: low battery on mains and on battery
        batt_low = 1; cyc(3);
        on_battery = 1; cyc(3);
        on_battery = 0; batt_low = 0; cyc(2);
        // R5/R6: fail with irq enabled, clear while still failing
        pwr_fail = 1; cyc(3);
        wr(2'd1, 7'h01); cyc(2);
        // R7: drop, reassert mid count, drop again and release at limit 30
        pwr_fail = 0; cyc(60);
        pwr_fail = 1; cyc(2);
        pwr_fail = 0; cyc(140);
        chk({39'd0, bus_lock}, 40'd0, "R7 released");
        // R5: clear racing a new rising edge, set must win
        wr(2'd1, 7'h01);
        pwr_fail = 1; wr_en = 1; wr_sel = 2'd1; wr_data = 7'h01;
        cyc();
        wr_en = 0; wr_sel = 2'd3; wr_data = '0;
        pwr_fail = 0; cyc(140);
        // R8: clamp below min, then a longer limit
        wr(2'd2, 7'd5);
        pwr_fail = 1; cyc(2); pwr_fail = 0; cyc(130);
        wr(2'd2, 7'd40);
        pwr_fail = 1; cyc(2); pwr_fail = 0; cyc(175);
        // R6/R5: masked interrupt still locks, no irq, no low-battery flag
        wr(2'd1, 7'h01);
        wr(2'd0, 7'b0000000);
        batt_low = 1;
        pwr_fail = 1; cyc(3); pwr_fail = 0; cyc(175);
        batt_low = 0;
        // R9/R10: time-save tracking
        wr(2'd0, 7'b0000100);
        upd(40'h12_05_0A_1E_2D); cyc();
        upd(40'h12_05_0A_1E_2E);
        pwr_fail = 1; cyc(2);
        upd(40'h12_05_0A_1F_00);
        pwr_fail = 0; cyc(2);
        wr(2'd0, 7'b0000000);
        upd(40'h11_11_11_11_11);
        wr(2'd0, 7'b0000100);
        upd(40'h22_22_22_22_22);
        on_battery = 1; cyc(2);
        upd(40'h33_33_33_33_33);
        chk(save_time, 40'h22_22_22_22_22, "R9/R10 save frozen on battery");
        on_battery = 0; cyc(2);
        // R10: clear on battery rise wins over a same-cycle enable write
        on_battery = 1; wr(2'd0, 7'b0000100);
        upd(40'h44_44_44_44_44);
        on_battery = 0; cyc(180);
        // R2: start the clock, then stop it: the flag stays clear
        wr(2'd0, 7'b0000001); cyc();
        wr(2'd0, 7'b0000000); cyc(2);
        chk({39'd0, osc_fail}, 40'd0, "R2 osc_fail cleared");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule